// File: doc/BRIEF.md
# UART Transmit/Receive Watermark Interrupt Unit

This unit sits between a UART's register interface and its serializer. It holds a small transmit byte queue. The bus side loads the queue with multi-byte write beats, and the serializer side drains it one byte per handshake. The unit compares the queue level with a programmable transmit threshold. It compares the receive FIFO level, which arrives as a plain input, with a receive threshold. The result is two pending bits. Each pending bit is gated by its enable bit, and the gated bits drive one level-sensitive interrupt line.

The write port is a valid/ready stream whose `wr_ready` is held high. The unit never applies back-pressure on writes. A beat that carries more bytes than the queue has room for is trimmed to fit. The bytes that do not fit are lost, and `wr_ovf` reports the loss. The drain port is a valid/ready stream. `tx_valid` is high while the queue holds a byte, and a byte leaves on each clock edge where `tx_valid` and `tx_ready` are both high.

After a byte leaves, the transmit comparison does not switch to the new level at once. For `TXI_DELAY` cycles it uses the level that was sampled before the pop. This models the short settling time that a real transmitter needs before its interrupt is re-evaluated.

`DEPTH` must be a power of two.

Top module: `uart_wm_irq`

## Requirements
- R1: `pend[0]` (transmit) is high exactly when the evaluated transmit level is strictly less than `tx_wm`. Outside a settle window, the evaluated level is the live queue occupancy. A `tx_wm` of 0 therefore never raises `pend[0]`.
- R2: `pend[1]` (receive) is high exactly when `rx_level` is strictly greater than `rx_wm`.
- R3: `irq` equals `(pend[0] & ie_rdata[0]) | (pend[1] & ie_rdata[1])` in every cycle. A cycle with `ie_wr` high loads `ie_wdata` into the enable register, which is read back on `ie_rdata`. Bit 0 enables transmit and bit 1 enables receive.
- R4: A write beat with `wr_valid` high accepts the smaller of the free slot count and `wr_len`, where `wr_len` values above `LANES` are treated as `LANES`. Lane i is `wr_data[8i+7:8i]`. Lanes enter the queue lowest first, and bytes leave in the order they entered.
- R5: `wr_ovf` is high for exactly the one cycle after a write beat whose capped length exceeded the free slot count. The bytes beyond the free space are discarded.
- R6: A write beat that is accepted with zero bytes leaves the queue contents and occupancy unchanged.
- R7: `tx_full` is high whenever the occupancy equals `DEPTH`. It goes low on the cycle after the first pop.
- R8: `tx_valid` is high whenever the queue is not empty, and `tx_data` shows the oldest byte. A pop occurs on a rising edge where `tx_valid` and `tx_ready` are both high.
- R9: A pop opens a settle window that lasts `TXI_DELAY` cycles after the most recent pop. Inside the window, R1 uses the occupancy sampled before the first pop of that window instead of the live occupancy.
- R10: After reset the queue is empty, the enable register is 0, `wr_ovf` is low, and the settle window is closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write beat valid |
| wr_ready | output | 1 | Always high; overflow is handled by dropping bytes |
| wr_len | input | $clog2(LANES+1) | Bytes offered in this beat |
| wr_data | input | 8*LANES | Byte lanes; lane 0 is queued first |
| wr_ovf | output | 1 | One-cycle pulse after a beat that lost bytes |
| tx_valid | output | 1 | Queue holds at least one byte |
| tx_ready | input | 1 | Serializer takes the head byte |
| tx_data | output | 8 | Oldest byte in the queue |
| tx_full | output | 1 | Queue is at `DEPTH` |
| tx_wm | input | WM_W | Transmit threshold |
| rx_wm | input | WM_W | Receive threshold |
| rx_level | input | $clog2(DEPTH+1) | Receive FIFO occupancy |
| ie_wr | input | 1 | Enable register write strobe |
| ie_wdata | input | 2 | Enable register write data |
| ie_rdata | output | 2 | Enable register value |
| pend | output | 2 | Pending bits: [0] transmit, [1] receive |
| irq | output | 1 | Interrupt request level |

## Verification
The inline assertions check the following on every cycle:
- occupancy never exceeds the depth;
- a beat that finds the queue full and no pop leaves the queue untouched;
- a pop from a full queue clears `tx_full` on the next cycle;
- an overflowing beat produces `wr_ovf`;
- a zero threshold never sets transmit pending;
- a receive level at or below its threshold never sets receive pending;
- cleared enables keep `irq` low;
- the first pop of a window freezes the evaluated transmit level.

Only the bench scenarios can show the rest, because that needs a reference queue: byte order across lanes and wrap-around, the exact trimmed count, and the value of the pending bits and `irq` through overlapping settle windows.

// File: rtl/uwm_pkg.sv
package uwm_pkg;
  // pending / enable bit positions
  localparam int unsigned SRC_TX = 0;
  localparam int unsigned SRC_RX = 1;
  localparam int unsigned NSRC   = 2;

  function automatic logic [31:0] umin(input logic [31:0] a, input logic [31:0] b);
    return (a < b) ? a : b;
  endfunction
endpackage

// File: rtl/uwm_txq.sv
module uwm_txq #(
  parameter int DEPTH = 8,
  parameter int LANES = 4,
  parameter int LW    = 3,
  parameter int OW    = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_valid,
  input  logic [LW-1:0]      wr_len,
  input  logic [8*LANES-1:0] wr_data,
  input  logic               pop,
  output logic [OW-1:0]      used,
  output logic [7:0]         head,
  output logic               ovf
);
  import uwm_pkg::*;
  localparam int AW = $clog2(DEPTH);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [OW-1:0] cnt;
  logic [31:0]   len_cap, free_cnt, acc32;
  logic [OW-1:0] acc;
  logic          over;

  assign len_cap  = umin(32'(wr_len), 32'(LANES));
  assign free_cnt = 32'(DEPTH) - 32'(cnt);
  assign acc32    = wr_valid ? umin(len_cap, free_cnt) : 32'd0;
  assign acc      = OW'(acc32);
  assign over     = wr_valid && (len_cap > free_cnt);

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++) begin
      if (32'(i) < acc32) mem[wp + AW'(i)] <= wr_data[8*i +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
      ovf <= 1'b0;
    end else begin
      wp  <= wp + AW'(acc);
      rp  <= rp + AW'(pop);
      cnt <= cnt + acc - OW'(pop);
      ovf <= over;
    end
  end

  assign used = cnt;
  assign head = mem[rp];

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt) <= 32'(DEPTH)); // R4
  AST_ZERO_ACCEPT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && 32'(cnt) == 32'(DEPTH) && !pop) |=> ($stable(cnt) && $stable(wp))); // R6
  AST_OVF_REPORTED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && len_cap > free_cnt) |=> ovf); // R5
endmodule

// File: rtl/uwm_txhold.sv
module uwm_txhold #(
  parameter int TXI_DELAY = 13,
  parameter int OW        = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pop,
  input  logic [OW-1:0] used,
  output logic [OW-1:0] used_eval
);
  localparam int HW = (TXI_DELAY > 0) ? $clog2(TXI_DELAY + 1) : 1;

  logic [HW-1:0] hold;
  logic [OW-1:0] frozen;
  logic          active;

  assign active = (hold != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold   <= '0;
      frozen <= '0;
    end else begin
      if (pop)         hold <= HW'(TXI_DELAY);
      else if (active) hold <= hold - 1'b1;
      if (!active)     frozen <= used;
    end
  end

  assign used_eval = active ? frozen : used;

  generate
    if (TXI_DELAY > 0) begin : g_chk
      AST_WINDOW_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !active) |=> (used_eval == $past(used))); // R9
    end
  endgenerate
endmodule

// File: rtl/uwm_irq.sv
module uwm_irq #(
  parameter int WM_W = 3,
  parameter int OW   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [OW-1:0]   tx_used_eval,
  input  logic [WM_W-1:0] tx_wm,
  input  logic [OW-1:0]   rx_level,
  input  logic [WM_W-1:0] rx_wm,
  input  logic            ie_wr,
  input  logic [1:0]      ie_wdata,
  output logic [1:0]      ie_q,
  output logic [1:0]      pend,
  output logic            irq
);
  import uwm_pkg::*;
  localparam int CW = (OW > WM_W) ? OW : WM_W;

  always_ff @(posedge clk) begin
    if (!rst_n)     ie_q <= '0;
    else if (ie_wr) ie_q <= ie_wdata;
  end

  always_comb begin
    pend         = '0;
    pend[SRC_TX] = CW'(tx_used_eval) < CW'(tx_wm);
    pend[SRC_RX] = CW'(rx_level) > CW'(rx_wm);
  end

  assign irq = |(pend & ie_q);

  AST_ZERO_TX_WM: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wm == '0) |-> !pend[SRC_TX]); // R1
  AST_RX_AT_OR_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
    (CW'(rx_level) <= CW'(rx_wm)) |-> !pend[SRC_RX]); // R2
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (ie_q == 2'b00) |-> !irq); // R3
endmodule

// File: rtl/uart_wm_irq.sv
module uart_wm_irq #(
  parameter int DEPTH     = 8,
  parameter int LANES     = 4,
  parameter int WM_W      = 3,
  parameter int TXI_DELAY = 13,
  localparam int OW = $clog2(DEPTH + 1),
  localparam int LW = $clog2(LANES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_valid,
  output logic               wr_ready,
  input  logic [LW-1:0]      wr_len,
  input  logic [8*LANES-1:0] wr_data,
  output logic               wr_ovf,
  output logic               tx_valid,
  input  logic               tx_ready,
  output logic [7:0]         tx_data,
  output logic               tx_full,
  input  logic [WM_W-1:0]    tx_wm,
  input  logic [WM_W-1:0]    rx_wm,
  input  logic [OW-1:0]      rx_level,
  input  logic               ie_wr,
  input  logic [1:0]         ie_wdata,
  output logic [1:0]         ie_rdata,
  output logic [1:0]         pend,
  output logic               irq
);
  logic [OW-1:0] used, used_eval;
  logic          pop;

  assign wr_ready = 1'b1;
  assign tx_valid = (used != '0);
  assign pop      = tx_valid && tx_ready;
  assign tx_full  = (32'(used) == 32'(DEPTH));

  uwm_txq #(.DEPTH(DEPTH), .LANES(LANES), .LW(LW), .OW(OW)) u_q (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_len(wr_len),
    .wr_data(wr_data), .pop(pop), .used(used), .head(tx_data), .ovf(wr_ovf)
  );

  uwm_txhold #(.TXI_DELAY(TXI_DELAY), .OW(OW)) u_hold (
    .clk(clk), .rst_n(rst_n), .pop(pop), .used(used), .used_eval(used_eval)
  );

  uwm_irq #(.WM_W(WM_W), .OW(OW)) u_irq (
    .clk(clk), .rst_n(rst_n), .tx_used_eval(used_eval), .tx_wm(tx_wm),
    .rx_level(rx_level), .rx_wm(rx_wm), .ie_wr(ie_wr), .ie_wdata(ie_wdata),
    .ie_q(ie_rdata), .pend(pend), .irq(irq)
  );

  AST_FULL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_full && tx_ready) |=> !tx_full); // R7
endmodule

// File: tb/uart_wm_irq_test.sv
`timescale 1ns/1ps
module uart_wm_irq_test;
  localparam int DEPTH = 8, LANES = 4, WM_W = 3, DLY = 13;
  localparam int OW = $clog2(DEPTH + 1), LW = $clog2(LANES + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_valid = 0, tx_ready = 0, ie_wr = 0;
  logic [LW-1:0] wr_len = '0;
  logic [8*LANES-1:0] wr_data = '0;
  logic [WM_W-1:0] tx_wm = '0, rx_wm = '0;
  logic [OW-1:0] rx_level = '0;
  logic [1:0] ie_wdata = '0;
  logic wr_ready, wr_ovf, tx_valid, tx_full, irq;
  logic [7:0] tx_data;
  logic [1:0] ie_rdata, pend;

  int n_chk = 0, n_bad = 0;
  logic [7:0] mq[$];
  int m_hold = 0, m_frozen = 0, m_ie = 0, m_ovf = 0;

  uart_wm_irq #(.DEPTH(DEPTH), .LANES(LANES), .WM_W(WM_W), .TXI_DELAY(DLY)) uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_len(wr_len), .wr_data(wr_data), .wr_ovf(wr_ovf), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .tx_full(tx_full), .tx_wm(tx_wm),
    .rx_wm(rx_wm), .rx_level(rx_level), .ie_wr(ie_wr), .ie_wdata(ie_wdata),
    .ie_rdata(ie_rdata), .pend(pend), .irq(irq)
  );

  always #4 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_pend();
    int lvl = (m_hold != 0) ? m_frozen : mq.size();
    int p = 0;
    if (lvl < int'(tx_wm)) p |= 1;
    if (int'(rx_level) > int'(rx_wm)) p |= 2;
    return p;
  endfunction

  // called at negedge with inputs applied; checks, then advances one edge
  task automatic cyc();
    int p, pop, cap, fr, acc;
    #1;
    p = exp_pend();
    chk("R1 tx pending", int'(pend[0]), p & 1);
    chk("R2 rx pending", int'(pend[1]), (p >> 1) & 1);
    chk("R3 irq", int'(irq), ((p & m_ie) != 0) ? 1 : 0);
    chk("R3 enable readback", int'(ie_rdata), m_ie);
    chk("R5 overflow flag", int'(wr_ovf), m_ovf);
    chk("R7 full flag", int'(tx_full), (mq.size() == DEPTH) ? 1 : 0);
    chk("R8 valid", int'(tx_valid), (mq.size() != 0) ? 1 : 0);
    chk("R4 write ready", int'(wr_ready), 1);
    if (mq.size() != 0) chk("R8 head byte order", int'(tx_data), int'(mq[0]));
    pop = (mq.size() != 0 && tx_ready) ? 1 : 0;
    cap = (int'(wr_len) > LANES) ? LANES : int'(wr_len);
    fr  = DEPTH - mq.size();
    acc = wr_valid ? ((cap < fr) ? cap : fr) : 0;
    @(posedge clk);
    m_ovf = (wr_valid && cap > fr) ? 1 : 0;
    if (m_hold == 0) m_frozen = mq.size();
    if (pop != 0) m_hold = DLY; else if (m_hold != 0) m_hold--;
    if (pop != 0) void'(mq.pop_front());
    for (int i = 0; i < acc; i++) mq.push_back(wr_data[8*i +: 8]);
    if (ie_wr) m_ie = int'(ie_wdata);
    @(negedge clk);
  endtask

  task automatic idle();
    wr_valid = 0; tx_ready = 0; ie_wr = 0;
  endtask

  task automatic wbeat(int len, int base);
    wr_valid = 1; wr_len = LW'(len);
    for (int i = 0; i < LANES; i++) wr_data[8*i +: 8] = 8'(base + i);
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10: reset state (empty, enables 0, no overflow)
    tx_wm = 3'd7; rx_wm = 3'd2; rx_level = 4'd2;
    cyc();
    chk("R10 reset empty", int'(tx_valid), 0);
    // enable both
    ie_wr = 1; ie_wdata = 2'b11; cyc(); idle();
    // R4: fill with two beats, then overflow (R5), then zero-accept (R6)
    wbeat(4, 8'h10); cyc();
    wbeat(7, 8'h20); cyc();          // length capped at LANES
    wbeat(3, 8'h30); cyc();          // queue full: all dropped, R5/R6
    wbeat(0, 8'h40); cyc(); idle();
    cyc();
    // R7: first pop clears full
    tx_ready = 1; cyc(); tx_ready = 0; cyc();
    // R5 partial: two free... one free, offer 3
    wbeat(3, 8'h50); cyc(); idle(); cyc();
    // R9: drain a few and watch the window expire
    tx_wm = 3'd6;
    tx_ready = 1; repeat (4) cyc(); tx_ready = 0;
    repeat (DLY + 3) cyc();
    // R1: zero threshold
    tx_wm = 3'd0; repeat (2) cyc();
    // R2: boundary levels
    rx_wm = 3'd3; rx_level = 4'd3; cyc(); rx_level = 4'd4; cyc();
    // R3: mask each source
    ie_wr = 1; ie_wdata = 2'b01; cyc(); ie_wdata = 2'b10; cyc(); ie_wdata = 2'b00; cyc(); idle();
    cyc();
    // random mix
    void'($urandom(32'h5eed1234));
    for (int k = 0; k < 4000; k++) begin
      wr_valid = ($urandom % 3) == 0;
      wr_len   = LW'($urandom % 8);
      wr_data  = 32'($urandom);
      tx_ready = ($urandom % 4) == 0;
      ie_wr    = ($urandom % 16) == 0;
      ie_wdata = 2'($urandom);
      if (($urandom % 32) == 0) tx_wm = WM_W'($urandom);
      if (($urandom % 8) == 0) rx_wm = WM_W'($urandom);
      rx_level = OW'($urandom % (DEPTH + 1));
      cyc();
    end
    idle();
    cyc();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end
endmodule